// File: doc/BRIEF.md
# Configurable AND-OR logic array

This block is a two-level sum-of-products array. Its configuration is held in link registers that are loaded at run time. Twelve dedicated inputs and ten bidirectional pins, each in true and complement form, can be linked into every AND term. Thirty-two logic terms feed ten OR gates through a link matrix. Each OR result then passes through its own polarity stage, which either keeps it or inverts it. Ten more AND terms act as control terms: control term n alone decides whether pin n drives. A pin can therefore serve as an input, as an output, or change role with the logic state.

The link map is written one word per address through a synchronous write port. It can be read back through a registered read port. Evaluation is combinational from the current link state. Every pin is split into a received value, a driven value and an output enable. While a pin is enabled, its own driven value replaces the external value inside the array.

Feedback is resolved by a fixed number of unrolled passes, set by `FB_PASSES`. A chain of enabled pins feeding one another settles correctly if it is at most `FB_PASSES-1` hops long. A loop through enabled pins is not supported.

Top module: `sop_array`

## Requirements
- R1: After a cycle with `rst` high, every link reads back as intact: AND words read all ones, and OR and polarity words read 10'h3FF. With those links, `pin_oe` is 0 and `pin_out` is 0 for any inputs.
- R2: A write takes effect at the clock edge where `cfg_we` is high. Outputs show the new link state right after that edge and not before.
- R3: AND word layout: signal k is `in_i[k]` for k below 12 and pin k-12 otherwise. Bit 2k is its true link and bit 2k+1 its complement link, where a bit value of 1 means intact. With only the true link intact, the term requires the signal high. With only the complement link intact, it requires the signal low. With neither, the signal is a don't care.
- R4: A term with both links of any one signal intact is 0, whatever the inputs. This holds for logic terms and control terms.
- R5: Addresses 0..31 hold the logic-term AND words. Address 64+t holds the OR word of logic term t, and its bit j links that term to output j. The raw output j is the OR of all linked logic terms.
- R6: The polarity word at address 96 has one bit per output. A value of 1 passes the raw OR value unchanged. A value of 0 inverts it.
- R7: The AND word of control term n sits at address 32+n. `pin_oe[n]` equals that term.
- R8: The array sees, for pin n, `pin_out[n]` when `pin_oe[n]` is 1 and `pin_in[n]` otherwise. Chains of enabled pins up to `FB_PASSES-1` hops deep resolve to the settled value.
- R9: Readback is registered. `cfg_rdata` shows the word at `cfg_raddr` one cycle after `cfg_re`, and it holds while `cfg_re` is low. OR and polarity words read zero-extended. Unmapped addresses read 0.
- R10: Writes to unmapped addresses change no link. Writes to OR and polarity words keep only the low 10 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, restores all links to intact |
| cfg_we | input | 1 | Write strobe for the link map |
| cfg_waddr | input | 7 | Write address |
| cfg_wdata | input | 44 | Write data |
| cfg_re | input | 1 | Read strobe |
| cfg_raddr | input | 7 | Read address |
| cfg_rdata | output | 44 | Registered readback word |
| in_i | input | 12 | Dedicated inputs |
| pin_in | input | 10 | Externally received pin values |
| pin_out | output | 10 | Value each pin would drive |
| pin_oe | output | 10 | Output enable per pin |

## Verification
A fixed map is walked through a vector table. In that map, one term mixes a true and a complement literal, one inverted output shares that term with a second term, and a control term follows an input. A two-hop chain runs from pin 0 through pin 2 to pin 3. The vectors flip the external value of an enabled pin and show that it is ignored, and they separate the enabled and disabled cases of pin 0. Directed steps change the polarity around a clock edge, place a link clash in a control term, and probe unmapped and over-wide writes through readback. Several random maps are then compared against a reference model that iterates to a fixed point. In these maps, terms that read pins only drive pins they do not read, so inversion, don't-care handling and feedback depth are exercised together.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;

  typedef enum logic [1:0] {
    RGN_AND,
    RGN_OR,
    RGN_POL,
    RGN_NONE
  } rgn_e;

  // Classify a configuration address into a storage region.
  function automatic rgn_e addr_region(input int a, input int n_and, input int or_base,
                                       input int n_term, input int pol_addr);
    if (a < n_and) return RGN_AND;
    if (a >= or_base && a < or_base + n_term) return RGN_OR;
    if (a == pol_addr) return RGN_POL;
    return RGN_NONE;
  endfunction

endpackage

// File: rtl/sop_link_regs.sv
module sop_link_regs
  import sop_array_pkg::*;
#(
  parameter int N_AND    = 42,
  parameter int N_TERM   = 32,
  parameter int N_PIN    = 10,
  parameter int AND_W    = 44,
  parameter int ADDR_W   = 7,
  parameter int OR_BASE  = 64,
  parameter int POL_ADDR = 96
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 waddr,
  input  logic [AND_W-1:0]                  wdata,
  input  logic                              re,
  input  logic [ADDR_W-1:0]                 raddr,
  output logic [AND_W-1:0]                  rdata,
  output logic [N_AND-1:0][AND_W-1:0]       and_q,
  output logic [N_TERM-1:0][N_PIN-1:0]      or_q,
  output logic [N_PIN-1:0]                  pol_q
);

  logic [AND_W-1:0] rd_next;
  logic             wr_mapped;

  always_ff @(posedge clk) begin
    if (rst) begin
      and_q <= '1;
      or_q  <= '1;
      pol_q <= '1;
    end else if (we) begin
      for (int i = 0; i < N_AND; i++)
        if (waddr == ADDR_W'(i)) and_q[i] <= wdata;
      for (int i = 0; i < N_TERM; i++)
        if (waddr == ADDR_W'(OR_BASE + i)) or_q[i] <= wdata[N_PIN-1:0];
      if (waddr == ADDR_W'(POL_ADDR)) pol_q <= wdata[N_PIN-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr_region(int'(raddr), N_AND, OR_BASE, N_TERM, POL_ADDR))
      RGN_AND: for (int i = 0; i < N_AND; i++)
                 if (raddr == ADDR_W'(i)) rd_next = and_q[i];
      RGN_OR:  for (int i = 0; i < N_TERM; i++)
                 if (raddr == ADDR_W'(OR_BASE + i)) rd_next = AND_W'(or_q[i]);
      RGN_POL: rd_next = AND_W'(pol_q);
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rd_next;
  end

  assign wr_mapped = addr_region(int'(waddr), N_AND, OR_BASE, N_TERM, POL_ADDR) != RGN_NONE;

  // R1
  links_intact_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((&and_q) && (&or_q) && (&pol_q)));

  // R2
  pol_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == ADDR_W'(POL_ADDR)) |=> (pol_q == $past(wdata[N_PIN-1:0])));

  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !wr_mapped) |=> ($stable(and_q) && $stable(or_q) && $stable(pol_q)));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_SIG = 22,
  parameter int N_AND = 42,
  localparam int AND_W = 2 * N_SIG
) (
  input  logic [N_AND-1:0][AND_W-1:0] links,
  input  logic [N_SIG-1:0]            sig,
  output logic [N_AND-1:0]            term
);

  always_comb begin
    for (int t = 0; t < N_AND; t++) begin
      term[t] = 1'b1;
      for (int k = 0; k < N_SIG; k++) begin
        if (links[t][2*k] && !sig[k])  term[t] = 1'b0;
        if (links[t][2*k+1] && sig[k]) term[t] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_TERM = 32,
  parameter int N_PIN  = 10
) (
  input  logic [N_TERM-1:0]            terms,
  input  logic [N_TERM-1:0][N_PIN-1:0] links,
  input  logic [N_PIN-1:0]             pol,
  output logic [N_PIN-1:0]             out
);

  logic [N_PIN-1:0] raw;

  always_comb begin
    raw = '0;
    for (int t = 0; t < N_TERM; t++)
      raw = raw | ({N_PIN{terms[t]}} & links[t]);
    out = raw ^ ~pol;
  end

endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_array_pkg::*;
#(
  parameter int N_IN      = 12,
  parameter int N_PIN     = 10,
  parameter int N_TERM    = 32,
  parameter int FB_PASSES = 4,
  localparam int N_SIG    = N_IN + N_PIN,
  localparam int AND_W    = 2 * N_SIG,
  localparam int N_AND    = N_TERM + N_PIN,
  localparam int OR_BASE  = 1 << $clog2(N_AND),
  localparam int POL_ADDR = OR_BASE + (1 << $clog2(N_TERM)),
  localparam int ADDR_W   = $clog2(POL_ADDR + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_waddr,
  input  logic [AND_W-1:0]  cfg_wdata,
  input  logic              cfg_re,
  input  logic [ADDR_W-1:0] cfg_raddr,
  output logic [AND_W-1:0]  cfg_rdata,
  input  logic [N_IN-1:0]   in_i,
  input  logic [N_PIN-1:0]  pin_in,
  output logic [N_PIN-1:0]  pin_out,
  output logic [N_PIN-1:0]  pin_oe
);

  function automatic logic [AND_W-1:0] even_bits();
    logic [AND_W-1:0] m;
    m = '0;
    for (int k = 0; k < N_SIG; k++) m[2*k] = 1'b1;
    return m;
  endfunction

  localparam logic [AND_W-1:0] EVEN_MASK = even_bits();

  logic [N_AND-1:0][AND_W-1:0]  and_w;
  logic [N_TERM-1:0][N_PIN-1:0] or_w;
  logic [N_PIN-1:0]             pol_w;

  sop_link_regs #(
    .N_AND(N_AND), .N_TERM(N_TERM), .N_PIN(N_PIN), .AND_W(AND_W),
    .ADDR_W(ADDR_W), .OR_BASE(OR_BASE), .POL_ADDR(POL_ADDR)
  ) u_links (
    .clk(clk), .rst(rst),
    .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
    .re(cfg_re), .raddr(cfg_raddr), .rdata(cfg_rdata),
    .and_q(and_w), .or_q(or_w), .pol_q(pol_w)
  );

  // Unrolled feedback: each pass sees the pin values the previous pass drove.
  for (genvar p = 0; p < FB_PASSES; p++) begin : g_pass
    logic [N_PIN-1:0] fb_in;
    logic [N_PIN-1:0] drv;
    logic [N_PIN-1:0] en;
    logic [N_AND-1:0] terms;

    if (p == 0) begin : g_first
      assign fb_in = pin_in;
    end else begin : g_next
      assign fb_in = (g_pass[p-1].en & g_pass[p-1].drv) | (~g_pass[p-1].en & pin_in);
    end

    sop_and_plane #(.N_SIG(N_SIG), .N_AND(N_AND)) u_and (
      .links(and_w), .sig({fb_in, in_i}), .term(terms)
    );

    sop_or_plane #(.N_TERM(N_TERM), .N_PIN(N_PIN)) u_or (
      .terms(terms[N_TERM-1:0]), .links(or_w), .pol(pol_w), .out(drv)
    );

    assign en = terms[N_AND-1:N_TERM];
  end

  assign pin_out = g_pass[FB_PASSES-1].drv;
  assign pin_oe  = g_pass[FB_PASSES-1].en;

  for (genvar n = 0; n < N_PIN; n++) begin : g_chk
    logic [AND_W-1:0]  cw;
    logic              clash;
    logic [N_TERM-1:0] col;

    assign cw    = and_w[N_TERM+n];
    assign clash = |(cw & (cw >> 1) & EVEN_MASK);

    always_comb
      for (int t = 0; t < N_TERM; t++) col[t] = or_w[t][n];

    // R4
    ctrl_clash_chk: assert property (@(posedge clk) disable iff (rst)
      clash |-> !pin_oe[n]);

    // R6
    empty_or_chk: assert property (@(posedge clk) disable iff (rst)
      (col == '0) |-> (pin_out[n] == !pol_w[n]));
  end

endmodule

// File: tb/test_sop_array.sv
`timescale 1ns/100ps
module test_sop_array;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_waddr = '0;
  logic [43:0] cfg_wdata = '0;
  logic        cfg_re = 1'b0;
  logic [6:0]  cfg_raddr = '0;
  logic [43:0] cfg_rdata;
  logic [11:0] in_i = '0;
  logic [9:0]  pin_in = '0;
  logic [9:0]  pin_out;
  logic [9:0]  pin_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sop_array i_sop_array (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_re(cfg_re), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .in_i(in_i), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {in_i, pin_in, expected pin_out, expected pin_oe} for the directed map
  localparam logic [41:0] VEC_TAB [8] = '{
    {12'h000, 10'h000, 10'h002, 10'h01E},
    {12'h001, 10'h000, 10'h001, 10'h01E},
    {12'h801, 10'h000, 10'h00D, 10'h01F},
    {12'h803, 10'h000, 10'h002, 10'h01F},
    {12'h004, 10'h001, 10'h00C, 10'h01E},
    {12'h400, 10'h3FF, 10'h00E, 10'h00E},
    {12'hC05, 10'h3FE, 10'h00D, 10'h00F},
    {12'h808, 10'h005, 10'h002, 10'h01F}
  };

  logic [43:0] ref_and [42];
  logic [9:0]  ref_or  [32];
  logic [9:0]  ref_pol;

  task automatic chk(input string tag, input logic [43:0] act, input logic [43:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [43:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [43:0] d);
    @(negedge clk);
    cfg_re = 1'b1; cfg_raddr = a;
    @(negedge clk);
    cfg_re = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic apply(input logic [11:0] i, input logic [9:0] p);
    @(negedge clk);
    in_i = i; pin_in = p;
    #1;
  endtask

  function automatic logic ref_term(input logic [43:0] w, input logic [21:0] s);
    for (int k = 0; k < 22; k++) begin
      if (w[2*k] && !s[k]) return 1'b0;
      if (w[2*k+1] && s[k]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic ref_eval(input logic [11:0] i, input logic [9:0] p,
                          output logic [9:0] o, output logic [9:0] e);
    logic [9:0] fb, raw, nfb;
    fb = p;
    for (int it = 0; it < 16; it++) begin
      raw = '0;
      for (int t = 0; t < 32; t++)
        if (ref_term(ref_and[t], {fb, i})) raw = raw | ref_or[t];
      o = raw ^ ~ref_pol;
      for (int n = 0; n < 10; n++) e[n] = ref_term(ref_and[32+n], {fb, i});
      nfb = (e & o) | (~e & p);
      if (nfb == fb) break;
      fb = nfb;
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [43:0] d;
    logic [9:0]  eo, ee;
    logic [43:0] w;
    bit          use_pins;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    apply(12'hFFF, 10'h3FF);
    chk("R1 pin_out", 44'(pin_out), 44'h0);
    chk("R1 pin_oe", 44'(pin_oe), 44'h0);
    rd(7'd0, d);  chk("R1 and word", d, 44'hFFF_FFFF_FFFF);
    rd(7'd41, d); chk("R1 ctrl word", d, 44'hFFF_FFFF_FFFF);
    rd(7'd64, d); chk("R1 or word", d, 44'h3FF);
    rd(7'd96, d); chk("R1 polarity", d, 44'h3FF);

    // Directed map
    wr(7'd0, 44'h9);          wr(7'd64, 44'h003);
    wr(7'd1, 44'h10);         wr(7'd65, 44'h002);
    wr(7'd2, 44'h100_0000);   wr(7'd66, 44'h004);
    wr(7'd3, 44'h1000_0000);  wr(7'd67, 44'h008);
    wr(7'd4, 44'hC0);         wr(7'd68, 44'h010);
    wr(7'd96, 44'h3FD);
    wr(7'd32, 44'h40_0000);
    wr(7'd33, 44'h0); wr(7'd34, 44'h0); wr(7'd35, 44'h0);
    wr(7'd36, 44'h20_0000);

    for (int v = 0; v < 8; v++) begin
      apply(VEC_TAB[v][41:30], VEC_TAB[v][29:20]);
      chk("R3/R5/R6/R8 pin_out", 44'(pin_out), 44'(VEC_TAB[v][19:10]));
      chk("R7 pin_oe", 44'(pin_oe), 44'(VEC_TAB[v][9:0]));
    end

    // R4: clashing logic term 4 stays off
    apply(12'h808, 10'h3FF);
    chk("R4 logic clash", 44'(pin_out[4]), 44'h0);
    // R4: clash in control term 5
    wr(7'd37, 44'h3);
    apply(12'h000, 10'h000); chk("R4 ctrl clash lo", 44'(pin_oe[5]), 44'h0);
    apply(12'h001, 10'h000); chk("R4 ctrl clash hi", 44'(pin_oe[5]), 44'h0);
    // R7: empty control term enables its pin
    wr(7'd37, 44'h0);
    apply(12'h000, 10'h000); chk("R7 ctrl empty", 44'(pin_oe[5]), 44'h1);

    // R2: write timing on polarity
    apply(12'h000, 10'h000);
    chk("R2 before write", 44'(pin_out), 44'h002);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = 7'd96; cfg_wdata = 44'h3FF;
    #2;
    chk("R2 pre-edge", 44'(pin_out), 44'h002);
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R2 post-edge", 44'(pin_out), 44'h000);
    wr(7'd96, 44'h3FD);

    // R9 / R10: unmapped and over-wide accesses
    wr(7'd50, 44'hFFF_FFFF_FFFF);
    rd(7'd50, d);  chk("R9 unmapped read", d, 44'h0);
    rd(7'd0, d);   chk("R10 and word kept", d, 44'h9);
    wr(7'd127, 44'hFFF_FFFF_FFFF);
    rd(7'd96, d);  chk("R10 polarity kept", d, 44'h3FD);
    wr(7'd69, 44'hFFF_FFFF_FFFF);
    rd(7'd69, d);  chk("R10 or word width", d, 44'h3FF);
    @(negedge clk); @(negedge clk);
    chk("R9 hold", cfg_rdata, 44'h3FF);
    apply(12'h000, 10'h000);
    chk("R10 outputs kept", 44'(pin_out), 44'h002);

    // Random maps against the reference model
    for (int m = 0; m < 6; m++) begin
      for (int t = 0; t < 32; t++) begin
        w = '0;
        use_pins = ($urandom % 2) == 1;
        for (int k = 0; k < 22; k++) begin
          int r;
          if (k >= 12 && (!use_pins || k >= 17)) continue;
          r = int'($urandom % 100);
          if (r < 9) w[2*k] = 1'b1;
          else if (r < 18) w[2*k+1] = 1'b1;
        end
        if (($urandom % 10) == 0) begin
          int kk;
          kk = int'($urandom % 12);
          w[2*kk] = 1'b1; w[2*kk+1] = 1'b1;
        end
        ref_and[t] = w;
        ref_or[t] = use_pins ? (10'($urandom) & 10'h3E0) : 10'($urandom);
      end
      for (int n = 0; n < 10; n++) begin
        w = '0;
        for (int k = 0; k < 12; k++) begin
          int r;
          r = int'($urandom % 100);
          if (r < 6) w[2*k] = 1'b1;
          else if (r < 12) w[2*k+1] = 1'b1;
        end
        if (($urandom % 7) == 0) begin
          int kk;
          kk = int'($urandom % 12);
          w[2*kk] = 1'b1; w[2*kk+1] = 1'b1;
        end
        ref_and[32+n] = w;
      end
      ref_pol = 10'($urandom);
      for (int a = 0; a < 42; a++) wr(7'(a), ref_and[a]);
      for (int t = 0; t < 32; t++) wr(7'(64 + t), 44'(ref_or[t]));
      wr(7'd96, 44'(ref_pol));
      for (int a = 0; a < 42; a++) begin
        rd(7'(a), d);
        chk("R9 random readback", d, ref_and[a]);
      end
      for (int v = 0; v < 40; v++) begin
        logic [11:0] ri;
        logic [9:0]  rp;
        ri = 12'($urandom);
        rp = 10'($urandom);
        apply(ri, rp);
        ref_eval(ri, rp, eo, ee);
        chk("R3/R5/R6/R8 random pin_out", 44'(pin_out), 44'(eo));
        chk("R4/R7 random pin_oe", 44'(pin_oe), 44'(ee));
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule